// File: doc/BRIEF.md
# Serial Register Control Port

This block is the slave side of a four-wire serial control bus: a serial clock, an active-low chip select, a data input line and a data output line. Through it a host reads and writes a bank of byte-wide configuration registers (41 by default). The block runs on the chip's own system clock. It resamples the four bus lines through synchronizer flops and detects the serial clock's edges in that clock domain. The register bank is presented as one flat vector to the logic it configures.

Every transaction opens with a command byte, shifted most significant bit first. Its top bit chooses read (1) or write (0). The next bit chooses a two-byte register access (1) or a lone synchronization byte (0). The low six bits name the register. For a register access a data byte follows, captured from the input line for a write or returned on the output line for a read. The output enable is raised only while read data is being returned, so the two data lines can share one wire. A pair of mode inputs switches the port on or off. When the port is off, the bus is ignored.

Top module: `sctl_port`

## Requirements
- R1: While reset is asserted and after its release, every register in the bank reads 0 and the output enable `ser_dout_en` is low.
- R2: Bits are sampled from `ser_din` on rising edges of `ser_clk` while `ser_csn` is low, most significant bit first. In the command byte, bit 7 is 1 for read and 0 for write, bit 6 is 1 for a two-byte register access, and bits 5..0 are the register address. Several transactions may follow one another inside one chip-select window.
- R3: A write stores the data byte in the addressed register only after the eighth data bit has been captured, and no other register changes.
- R4: A read returns the addressed register on `ser_dout`, most significant bit first. Each bit is updated on a falling edge of `ser_clk`, and the first falling edge after the command byte presents bit 7. The read changes no register.
- R5: `ser_dout_en` is high only from the end of a read command byte until the eighth rising edge of its data byte. It is low during write commands, write data and idle time.
- R6: A command byte with bit 6 equal to 0 is a one-byte synchronization command. It changes no register, it never raises `ser_dout_en`, and the next byte is taken as a new command.
- R7: A write to an address of 41 or above changes no register, and a read from such an address returns 0x00.
- R8: Raising `ser_csn` aborts any partial command or data byte. It resets the bit count, drops `ser_dout_en`, and leaves the registers unchanged, so the next byte starts a fresh command.
- R9: The port is active only when `mode0` is 0 and `mode1` is 1. In any other mode the bus is ignored: no register changes and `ser_dout_en` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode0 | input | 1 | Mode select bit 0 (port on needs 0) |
| mode1 | input | 1 | Mode select bit 1 (port on needs 1) |
| ser_clk | input | 1 | Serial bus clock |
| ser_csn | input | 1 | Serial chip select, active low |
| ser_din | input | 1 | Serial data from host |
| ser_dout | output | 1 | Serial data to host |
| ser_dout_en | output | 1 | Drive enable for the shared data pad |
| cfg_flat | output | NUM_REGS*DATA_W | Register bank, register n at bits n*8+7..n*8 |

## Verification
The bench writes, reads and aborts bytes with asymmetric bit patterns such as 0x2C and address 2. A reversed bit order or a swapped command field then lands in a visibly different register or value. Back-to-back accesses inside one chip-select window and synchronization bytes placed between them show whether byte framing recovers without a chip-select edge. Writes and reads at address 40 and at 41 and 63 separate the last valid register from out-of-range accesses. Aborts in the middle of the command byte, the write data and the read data, plus transactions in each disabled mode, show that partial or ignored traffic leaves the bank and the output enable untouched.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

   typedef enum logic [1:0] {
      PH_CMD = 2'd0,
      PH_WR  = 2'd1,
      PH_RD  = 2'd2
   } phase_t;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] q_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sctl_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= RST_VAL;
            else        stg[0] <= d_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q_out = stg[STAGES-1];

endmodule

// File: rtl/sctl_framer.sv
module sctl_framer
   import sctl_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              din_s,
   input  logic              halt,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] acc_addr,
   output logic              wr_req,
   output logic [DATA_W-1:0] wr_data,
   output logic              dout,
   output logic              dout_en
);

   localparam int CMD_W = ADDR_W + 2;
   localparam int SH_W  = imax(CMD_W, DATA_W);
   localparam int CNT_W = $clog2(SH_W + 1);
   localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W - 1);
   localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DATA_W - 1);

   phase_t            ph;
   logic [CNT_W-1:0]  cnt;
   logic [SH_W-1:0]   sh;
   logic [SH_W-1:0]   nxt;
   logic [DATA_W-1:0] rd_sh;
   logic              primed;
   logic              sclk_q;
   logic              rise, fall, byte_done;
   logic [CNT_W-1:0]  last;

   assign rise      = sclk_s & ~sclk_q & ~halt;
   assign fall      = ~sclk_s & sclk_q & ~halt;
   assign nxt       = {sh[SH_W-2:0], din_s};
   assign last      = (ph == PH_CMD) ? CMD_LAST : DAT_LAST;
   assign byte_done = rise && (cnt == last);
   assign wr_req    = byte_done && (ph == PH_WR);
   assign wr_data   = nxt[DATA_W-1:0];
   assign dout_en   = (ph == PH_RD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph       <= PH_CMD;
         cnt      <= '0;
         sh       <= '0;
         rd_sh    <= '0;
         primed   <= 1'b0;
         sclk_q   <= 1'b0;
         acc_addr <= '0;
         dout     <= 1'b0;
      end else begin
         sclk_q <= sclk_s;
         if (halt) begin
            ph     <= PH_CMD;
            cnt    <= '0;
            primed <= 1'b0;
            dout   <= 1'b0;
         end else if (rise) begin
            sh <= nxt;
            if (cnt == last) begin
               cnt <= '0;
               unique case (ph)
                  PH_CMD: begin
                     if (nxt[CMD_W-2]) begin
                        acc_addr <= nxt[ADDR_W-1:0];
                        ph       <= nxt[CMD_W-1] ? PH_RD : PH_WR;
                        primed   <= 1'b0;
                     end
                  end
                  PH_WR:   ph <= PH_CMD;
                  PH_RD:   ph <= PH_CMD;
                  default: ph <= PH_CMD;
               endcase
            end else begin
               cnt <= cnt + 1'b1;
            end
         end else if (fall && ph == PH_RD) begin
            if (!primed) begin
               dout   <= rd_data[DATA_W-1];
               rd_sh  <= rd_data << 1;
               primed <= 1'b1;
            end else begin
               dout  <= rd_sh[DATA_W-1];
               rd_sh <= rd_sh << 1;
            end
         end
      end
   end

   // R8: a raised chip select or disabled port returns framing to a fresh command
   a_r8_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> (ph == PH_CMD && cnt == '0));

   // R5: the enable only rises on a captured serial clock rising edge
   a_r5_oe_rise_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dout_en) |-> $past(rise));

   // R5: the enable only falls at a data byte end or on an abort
   a_r5_oe_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dout_en) |-> ($past(halt) || $past(byte_done)));

   // R6: a synchronization byte leaves framing at the command stage
   a_r6_sync_stays_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && ph == PH_CMD && !nxt[CMD_W-2]) |=> (ph == PH_CMD && !dout_en));

endmodule

// File: rtl/sctl_regbank.sv
module sctl_regbank #(
   parameter int NUM_REGS = 41,
   parameter int ADDR_W   = 6,
   parameter int DATA_W   = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_req,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [DATA_W-1:0]          wr_data,
   output logic [DATA_W-1:0]          rd_data,
   output logic [NUM_REGS*DATA_W-1:0] cfg_flat
);

   localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(NUM_REGS);

   logic [DATA_W-1:0] regs [NUM_REGS];
   logic              in_range;

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs[r] <= '0;
         else if (wr_req && addr == ADDR_W'(r))
            regs[r] <= wr_data;
      end
      assign cfg_flat[r*DATA_W +: DATA_W] = regs[r];
   end

   if (NUM_REGS == (1 << ADDR_W)) begin : g_full_map
      assign in_range = 1'b1;
      assign rd_data  = regs[addr];
   end else begin : g_part_map
      assign in_range = ({1'b0, addr} < LIMIT);
      assign rd_data  = in_range ? regs[addr] : '0;
   end

   // R3: a write with a valid address lands in the addressed register
   a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && in_range) |=> cfg_flat[$past(addr)*DATA_W +: DATA_W] == $past(wr_data));

   // R7: a write beyond the bank leaves every register as it was
   a_r7_oob_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !in_range) |=> $stable(cfg_flat));

endmodule

// File: rtl/sctl_port.sv
module sctl_port #(
   parameter int NUM_REGS    = 41,
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       mode0,
   input  logic                       mode1,
   input  logic                       ser_clk,
   input  logic                       ser_csn,
   input  logic                       ser_din,
   output logic                       ser_dout,
   output logic                       ser_dout_en,
   output logic [NUM_REGS*DATA_W-1:0] cfg_flat
);

   if (NUM_REGS < 1 || NUM_REGS > (1 << ADDR_W)) begin : g_bad_regs
      $error("sctl_port: NUM_REGS must fit the address field");
   end
   if (DATA_W < 2 || ADDR_W < 1) begin : g_bad_widths
      $error("sctl_port: DATA_W must be >= 2 and ADDR_W >= 1");
   end

   localparam int PIN_W = 5;

   logic [PIN_W-1:0]  pins_s;
   logic              sclk_s, csn_s, din_s, port_on, halt;
   logic [ADDR_W-1:0] acc_addr;
   logic              wr_req;
   logic [DATA_W-1:0] wr_data, rd_data;

   sctl_sync #(
      .W       (PIN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (5'b00100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({mode1, mode0, ser_csn, ser_clk, ser_din}),
      .q_out (pins_s)
   );

   assign din_s   = pins_s[0];
   assign sclk_s  = pins_s[1];
   assign csn_s   = pins_s[2];
   assign port_on = ~pins_s[3] & pins_s[4];
   assign halt    = csn_s | ~port_on;

   sctl_framer #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_framer (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk_s   (sclk_s),
      .din_s    (din_s),
      .halt     (halt),
      .rd_data  (rd_data),
      .acc_addr (acc_addr),
      .wr_req   (wr_req),
      .wr_data  (wr_data),
      .dout     (ser_dout),
      .dout_en  (ser_dout_en)
   );

   sctl_regbank #(
      .NUM_REGS (NUM_REGS),
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_req   (wr_req),
      .addr     (acc_addr),
      .wr_data  (wr_data),
      .rd_data  (rd_data),
      .cfg_flat (cfg_flat)
   );

   // R9: a disabled port drops the output enable on the next cycle
   a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !port_on |=> !ser_dout_en);

   // R4: while read data is returned the bank does not change
   a_r4_read_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      ser_dout_en |=> $stable(cfg_flat));

   // R1: the enable is never raised without an active chip select
   a_r1_oe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
      ser_dout_en |-> $past(!halt));

endmodule

// File: tb/sctl_port_bench.sv
module sctl_port_bench;

   localparam int NR = 41;
   localparam int DW = 8;
   localparam int HP = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode0 = 1'b0, mode1 = 1'b1;
   logic csn = 1'b1, sclk = 1'b0, sdi = 1'b0;
   logic dout, dout_en;
   logic [NR*DW-1:0] cfg;

   always #5 clk = ~clk;

   sctl_port u_sctl_port (
      .clk(clk), .rst_n(rst_n), .mode0(mode0), .mode1(mode1),
      .ser_clk(sclk), .ser_csn(csn), .ser_din(sdi),
      .ser_dout(dout), .ser_dout_en(dout_en), .cfg_flat(cfg)
   );

   int total = 0, bad = 0, since = 0;
   bit done = 1'b0;
   logic [7:0] mref [NR];
   int nb = 0, ph = 0, ad = 0, rdi = 0;
   logic [7:0] acc = '0, rdb = '0;
   logic oe_ref = 1'b0, sdo_ref = 1'b0, sdo_vld = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic bit on_ref();
      return !mode0 && mode1;
   endfunction

   task automatic model_abort();
      nb = 0; ph = 0; oe_ref = 1'b0; sdo_vld = 1'b0;
   endtask

   task automatic model_rise(input logic b);
      if (csn || !on_ref()) return;
      acc = {acc[6:0], b};
      nb++;
      if (nb == 8) begin
         nb = 0;
         if (ph == 0) begin
            if (acc[6]) begin
               ad = int'(acc[5:0]);
               if (acc[7]) begin
                  ph = 2; rdi = 0; oe_ref = 1'b1; sdo_vld = 1'b0;
                  rdb = (ad < NR) ? mref[ad] : 8'h00;
               end else ph = 1;
            end
         end else if (ph == 1) begin
            if (ad < NR) mref[ad] = acc;
            ph = 0;
         end else begin
            ph = 0; oe_ref = 1'b0; sdo_vld = 1'b0;
         end
      end
   endtask

   task automatic model_fall();
      if (csn || !on_ref() || ph != 2 || rdi > 7) return;
      sdo_ref = rdb[7-rdi];
      rdi++;
      sdo_vld = 1'b1;
   endtask

   always @(posedge clk) since++;

   // Reference comparison on every settled clock
   always @(negedge clk) begin
      if (rst_n && since >= 6 && !done) begin
         logic [NR*DW-1:0] expv;
         for (int r = 0; r < NR; r++) expv[r*DW +: DW] = mref[r];
         total++;
         if (cfg !== expv) begin
            bad++;
            $display("FAIL R3 R6 R7 R8 R9 bank image act=%h exp=%h", cfg, expv);
         end
         chk("R5 output enable vs model", 32'(dout_en), 32'(oe_ref));
         if (oe_ref && sdo_vld) chk("R4 read bit vs model", 32'(dout), 32'(sdo_ref));
      end
   end

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic set_csn(input logic v);
      csn = v; since = 0;
      if (v) model_abort();
   endtask

   task automatic set_mode(input logic m0, input logic m1);
      mode0 = m0; mode1 = m1; since = 0;
      if (!on_ref()) model_abort();
      idle(2*HP);
   endtask

   task automatic bit_out(input logic b, output logic seen, output logic seen_oe);
      sdi = b; since = 0;
      idle(HP);
      seen = dout; seen_oe = dout_en;
      sclk = 1'b1; since = 0; model_rise(b);
      idle(HP);
      sclk = 1'b0; since = 0; model_fall();
   endtask

   task automatic send_byte(input logic [7:0] b, input int n);
      logic s, so;
      for (int i = 0; i < n; i++) bit_out(b[7-i], s, so);
   endtask

   task automatic open_tx();
      set_csn(1'b0); idle(HP);
   endtask

   task automatic close_tx();
      set_csn(1'b1); idle(2*HP);
   endtask

   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      logic s, so;
      send_byte({2'b01, a}, 8);
      for (int i = 0; i < 8; i++) begin
         bit_out(d[7-i], s, so);
         if (i == 0) chk("R5 enable low during write data", 32'(so), 32'(0));
      end
   endtask

   task automatic rd(input logic [5:0] a, output logic [7:0] got, output logic oe0);
      logic s, so;
      send_byte({2'b11, a}, 8);
      for (int i = 0; i < 8; i++) begin
         bit_out(1'b0, s, so);
         got[7-i] = s;
         if (i == 0) oe0 = so;
      end
   endtask

   logic [7:0] got;
   logic oe0;
   logic [NR*DW-1:0] snap;

   initial begin
      for (int r = 0; r < NR; r++) mref[r] = 8'h00;
      idle(3);
      chk("R1 bank zero in reset", 32'(cfg == '0), 32'(1));
      chk("R1 enable low in reset", 32'(dout_en), 32'(0));
      rst_n = 1'b1; since = 0;
      idle(2*HP);
      chk("R1 bank zero after reset", 32'(cfg == '0), 32'(1));
      chk("R1 enable low after reset", 32'(dout_en), 32'(0));

      // R2 R3: asymmetric data and address
      open_tx(); wr(6'd3, 8'h2C); close_tx();
      chk("R3 reg3 written", 32'(cfg[3*8 +: 8]), 32'h2C);
      chk("R3 reg2 untouched", 32'(cfg[2*8 +: 8]), 32'h00);
      open_tx(); wr(6'd2, 8'h81); close_tx();
      chk("R2 address msb first reg2", 32'(cfg[2*8 +: 8]), 32'h81);
      chk("R2 reversed address reg16 untouched", 32'(cfg[16*8 +: 8]), 32'h00);

      // R4 R5: read back
      open_tx(); rd(6'd3, got, oe0);
      chk("R5 enable high during read data", 32'(oe0), 32'(1));
      close_tx();
      chk("R4 read reg3", 32'(got), 32'h2C);
      chk("R5 enable low after read", 32'(dout_en), 32'(0));
      chk("R4 read keeps reg3", 32'(cfg[3*8 +: 8]), 32'h2C);

      // R2: back-to-back in one select window, last valid register
      open_tx(); wr(6'd0, 8'hFF); wr(6'd40, 8'h5A); rd(6'd40, got, oe0); close_tx();
      chk("R2 back-to-back reg0", 32'(cfg[0*8 +: 8]), 32'hFF);
      chk("R7 last valid reg40 write", 32'(cfg[40*8 +: 8]), 32'h5A);
      chk("R2 back-to-back read reg40", 32'(got), 32'h5A);

      // R7: out of range
      snap = cfg;
      open_tx(); wr(6'd41, 8'h77); close_tx();
      chk("R7 write to 41 ignored", 32'(cfg == snap), 32'(1));
      open_tx(); rd(6'd41, got, oe0); close_tx();
      chk("R7 read 41 is zero", 32'(got), 32'h00);
      open_tx(); rd(6'd63, got, oe0); close_tx();
      chk("R7 read 63 is zero", 32'(got), 32'h00);

      // R6: synchronization bytes
      open_tx(); send_byte(8'h3F, 8); wr(6'd5, 8'hC3); close_tx();
      chk("R6 write after sync byte", 32'(cfg[5*8 +: 8]), 32'hC3);
      open_tx(); send_byte(8'hBF, 8); idle(HP);
      chk("R6 sync with read bit keeps enable low", 32'(dout_en), 32'(0));
      send_byte(8'h05, 8); wr(6'd6, 8'h3C); close_tx();
      chk("R6 sync naming reg5 changes nothing", 32'(cfg[5*8 +: 8]), 32'hC3);
      chk("R6 write after two syncs", 32'(cfg[6*8 +: 8]), 32'h3C);

      // R8: aborts
      open_tx(); send_byte(8'h47, 8); send_byte(8'hFF, 5); close_tx();
      chk("R8 partial write data dropped", 32'(cfg[7*8 +: 8]), 32'h00);
      open_tx(); wr(6'd7, 8'h81); close_tx();
      chk("R8 fresh command after abort", 32'(cfg[7*8 +: 8]), 32'h81);
      open_tx(); send_byte(8'h4F, 4); close_tx();
      open_tx(); wr(6'd8, 8'h42); close_tx();
      chk("R8 partial command dropped", 32'(cfg[8*8 +: 8]), 32'h42);
      open_tx(); send_byte(8'hC3, 8); send_byte(8'h00, 3);
      chk("R5 enable high mid read", 32'(dout_en), 32'(1));
      close_tx();
      chk("R8 abort drops enable", 32'(dout_en), 32'(0));

      // R9: disabled modes
      set_mode(1'b1, 1'b0);
      open_tx(); wr(6'd9, 8'h99); send_byte(8'hC3, 8); idle(HP);
      chk("R9 no enable when off", 32'(dout_en), 32'(0));
      close_tx();
      chk("R9 write ignored mode 10", 32'(cfg[9*8 +: 8]), 32'h00);
      set_mode(1'b0, 1'b0);
      open_tx(); wr(6'd9, 8'h99); close_tx();
      chk("R9 write ignored mode 00", 32'(cfg[9*8 +: 8]), 32'h00);
      set_mode(1'b1, 1'b1);
      open_tx(); wr(6'd9, 8'h99); close_tx();
      chk("R9 write ignored mode 11", 32'(cfg[9*8 +: 8]), 32'h00);
      set_mode(1'b0, 1'b1);
      open_tx(); wr(6'd9, 8'h99); close_tx();
      chk("R9 write works when on", 32'(cfg[9*8 +: 8]), 32'h99);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule